// File: doc/BRIEF.md
# Table-Driven Systematic LDPC Encoder

This block turns a serial stream of message bits into systematic codewords of a sparse parity-check code. Each block holds `K` message bits and produces an `N`-bit codeword. The first `K` codeword bits are the message bits, unchanged and in arrival order. The remaining `N-K` bits are parity bits. Every parity bit is the GF(2) sum of a subset of the message bits.

The logic does not compute which parity bits a message bit feeds. That information sits in a small on-chip table with one entry per message position. Each entry has `W` slots. A slot is a parity index plus an enable flag in the top bit of the slot. The table is loaded through a plain write port before encoding starts.

For each message bit, only that bit's entry is read. The read overlaps with the accumulation of the previous bit, so message bits can arrive on back-to-back cycles. Message bits are forwarded to the output as they are absorbed. After the last one, the parity register is shifted out, lowest index first. Both streams use valid/ready handshakes. The output carries start-of-codeword and end-of-codeword markers.

Top module: `ldpc_tbl_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first `K` output bits of each codeword equal the accepted message bits in acceptance order, and `out_sop` is 1 on the first of them.
- R3: Output parity bit `j` (codeword position `K+j`) is the XOR of all message bits `i` whose table entry holds an enabled slot with index `j`. With the reference table {c1→p0,p2; c2→p0,p1,p2; c3→p1,p2}, message 110 gives 110010. The received codeword has an all-zero syndrome.
- R4: Table slot `s` occupies bits `[s*(PIW+1) +: PIW+1]`. Its low `PIW` bits are the parity index and its top bit is the enable. A disabled slot has no effect. An enabled index of `N-K` or more has no effect. Two enabled slots with the same index cancel.
- R5: The parity register is cleared at the start of every codeword, so parity depends only on the current block.
- R6: With `out_ready` held at 1, `in_ready` stays at 1 for `K` consecutive cycles. The first output bit appears two clock edges after the first accept, and all `N` codeword bits appear on `N` consecutive cycles.
- R7: After the `K`-th message bit is accepted, `in_ready` stays at 0 until the last parity bit is presented on the output.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output bit and both markers stay unchanged on the next cycle. No bit is lost or repeated.
- R9: `out_eop` is 1 only on codeword bit `N-1`, and `out_sop` is 1 only on codeword bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | AW | Message position of the table entry being written |
| tbl_wdata | input | W*(PIW+1) | Table entry: W slots of {enable, parity index} |
| in_valid | input | 1 | Message bit valid |
| in_data | input | 1 | Message bit |
| in_ready | output | 1 | Encoder accepts a message bit |
| out_valid | output | 1 | Codeword bit valid |
| out_data | output | 1 | Codeword bit |
| out_sop | output | 1 | First bit of a codeword |
| out_eop | output | 1 | Last bit of a codeword |
| out_ready | input | 1 | Downstream accepts the codeword bit |

## Verification
A stale or uncleared parity register appears only at the parity positions, one codeword later. It is caught by a bad syndrome on the next block. A sweep over all messages is therefore run with blocks back to back. A wrong table read or a read that is not held during a stall flips specific parity bits. This is caught by comparing each block's parity against a model, under both steady and irregular backpressure. Faults in the sequencing show up within a single codeword. They appear as a marker on the wrong bit, a gap in a back-to-back burst, or `in_ready` rising before the parity has been shown.

// File: rtl/ldpc_enc_pkg.sv
package ldpc_enc_pkg;
  typedef enum logic [1:0] {
    ST_MSG   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_PAR   = 2'd2
  } enc_state_e;
endpackage

// File: rtl/ldpc_tbl_ram.sv
module ldpc_tbl_ram #(
  parameter int DEPTH = 3,
  parameter int AW    = 2,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ldpc_par_acc.sv
module ldpc_par_acc #(
  parameter int NP  = 3,
  parameter int W   = 3,
  parameter int PIW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic                clear,
  input  logic                bit_i,
  input  logic [W*(PIW+1)-1:0] entry,
  output logic [NP-1:0]       acc_o
);
  localparam int SW = PIW + 1;

  function automatic logic [NP-1:0] slot_mask(input logic [W*SW-1:0] e);
    logic [NP-1:0]  m;
    logic [PIW-1:0] ix;
    m = '0;
    for (int s = 0; s < W; s++) begin
      ix = e[s*SW +: PIW];
      if (e[s*SW+PIW] && (int'(ix) < NP)) m[ix] = ~m[ix];
    end
    return m;
  endfunction

  logic [NP-1:0] base;
  logic [NP-1:0] acc_d;

  always_comb begin
    base  = clear ? '0 : acc_o;
    acc_d = base ^ (bit_i ? slot_mask(entry) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_o <= '0;
    else if (upd) acc_o <= acc_d;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && clear && !bit_i) |=> (acc_o == '0)); // R5
endmodule

// File: rtl/ldpc_tbl_encoder.sv
module ldpc_tbl_encoder #(
  parameter int K = 3,
  parameter int N = 6,
  parameter int W = 3,
  parameter int NP  = N - K,
  parameter int PIW = (NP > 1) ? $clog2(NP) : 1,
  parameter int AW  = (K > 1) ? $clog2(K) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic [W*(PIW+1)-1:0] tbl_wdata,
  input  logic                 in_valid,
  input  logic                 in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_data,
  output logic                 out_sop,
  output logic                 out_eop,
  input  logic                 out_ready
);
  import ldpc_enc_pkg::*;

  localparam int DW = W * (PIW + 1);
  localparam int CW = (NP > 1) ? $clog2(NP) : 1;

  enc_state_e    state;
  logic [AW-1:0] bit_cnt;
  logic [CW-1:0] par_cnt;
  logic          s1_valid, s1_bit, s1_first;
  logic [DW-1:0] entry;
  logic [NP-1:0] acc;

  // named internal events
  logic adv, s1_mv, in_acc, last_in, par_mv, last_par;

  always_comb begin
    adv      = !out_valid || out_ready;
    s1_mv    = s1_valid && adv;
    in_ready = (state == ST_MSG) && (!s1_valid || adv);
    in_acc   = in_valid && in_ready;
    last_in  = in_acc && (bit_cnt == AW'(K-1));
    par_mv   = (state == ST_PAR) && adv;
    last_par = par_mv && (par_cnt == CW'(NP-1));
  end

  ldpc_tbl_ram #(.DEPTH(K), .AW(AW), .DW(DW)) tbl_i (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .re    (in_acc),
    .raddr (bit_cnt),
    .rdata (entry)
  );

  ldpc_par_acc #(.NP(NP), .W(W), .PIW(PIW)) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (s1_mv),
    .clear (s1_first),
    .bit_i (s1_bit),
    .entry (entry),
    .acc_o (acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_MSG;
      bit_cnt  <= '0;
      par_cnt  <= '0;
      s1_valid <= 1'b0;
      s1_bit   <= 1'b0;
      s1_first <= 1'b0;
    end else begin
      if (in_acc) begin
        s1_valid <= 1'b1;
        s1_bit   <= in_data;
        s1_first <= (bit_cnt == '0);
        bit_cnt  <= last_in ? '0 : bit_cnt + 1'b1;
      end else if (s1_mv) begin
        s1_valid <= 1'b0;
      end
      if (par_mv) par_cnt <= last_par ? '0 : par_cnt + 1'b1;
      unique case (state)
        ST_MSG:   if (last_in)  state <= ST_DRAIN;
        ST_DRAIN: if (s1_mv)    state <= ST_PAR;
        ST_PAR:   if (last_par) state <= ST_MSG;
        default:                state <= ST_MSG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (s1_mv) begin
      out_valid <= 1'b1;
      out_data  <= s1_bit;
      out_sop   <= s1_first;
      out_eop   <= 1'b0;
    end else if (par_mv) begin
      out_valid <= 1'b1;
      out_data  <= acc[par_cnt];
      out_sop   <= 1'b0;
      out_eop   <= (par_cnt == CW'(NP-1));
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))); // R8
  AST_NO_ACCEPT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_in |=> !in_ready); // R7
  AST_SOP_EOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sop && out_eop)); // R9
  AST_PARITY_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eop && state != ST_MSG) |=> out_valid); // R6
endmodule

// File: tb/ldpc_tbl_encoder_tb_top.sv
module ldpc_tbl_encoder_tb_top;
  localparam int K = 3;
  localparam int N = 6;
  localparam int W = 3;
  localparam int NP = N - K;
  localparam int PIW = 2;
  localparam int AW = 2;
  localparam int SW = PIW + 1;

  logic clk = 0;
  logic rst_n = 0;
  logic tbl_we = 0;
  logic [AW-1:0] tbl_addr = '0;
  logic [W*SW-1:0] tbl_wdata = '0;
  logic in_valid = 0, in_data = 0, in_ready;
  logic out_valid, out_data, out_sop, out_eop;
  logic out_ready = 1;

  int tests = 0, fails = 0, cyc = 0;
  logic last_in_done = 0;
  logic [7:0] lfsr = 8'hA5;

  logic t_en [K][W];
  int   t_ix [K][W];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ldpc_tbl_encoder #(.K(K), .N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] model(input logic [K-1:0] m);
    logic [NP-1:0] p = '0;
    for (int i = 0; i < K; i++)
      for (int s = 0; s < W; s++)
        if (m[i] && t_en[i][s] && t_ix[i][s] < NP) p[t_ix[i][s]] = ~p[t_ix[i][s]];
    return p;
  endfunction

  task automatic load_table();
    for (int i = 0; i < K; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = AW'(i);
      for (int s = 0; s < W; s++)
        tbl_wdata[s*SW +: SW] = {t_en[i][s], PIW'(t_ix[i][s])};
    end
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic set_slot(input int i, input int s, input logic en, input int ix);
    t_en[i][s] = en; t_ix[i][s] = ix;
  endtask

  // msg[0] is the first bit sent; returns codeword in cw[0..N-1]
  task automatic run_block(input logic [K-1:0] msg, input int mode, input string ptag,
                           output logic [N-1:0] cw);
    int acc_st [K];
    int out_st [N];
    logic sops [N];
    logic eops [N];
    bit gate_err = 0, stall_err = 0;
    logic [NP-1:0] ep, rp, syn;
    fork
      begin
        for (int i = 0; i < K; i++) begin
          @(negedge clk); in_valid = 1; in_data = msg[i]; #2;
          while (!in_ready) begin @(negedge clk); #2; end
          acc_st[i] = cyc;
          @(posedge clk);
        end
        last_in_done = 1;
        @(negedge clk); in_valid = 0;
      end
      begin
        int got = 0;
        logic sp = 0, pd = 0, ps = 0, pe = 0;
        while (got < N) begin
          @(negedge clk);
          out_ready = (mode != 0) ? (lfsr[0] | lfsr[2]) : 1'b1;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          #1;
          if (sp && !(out_valid && out_data == pd && out_sop == ps && out_eop == pe)) stall_err = 1;
          if (last_in_done && !(out_valid && out_eop) && in_ready) gate_err = 1;
          if (out_valid && out_ready) begin
            cw[got] = out_data; sops[got] = out_sop; eops[got] = out_eop;
            out_st[got] = cyc;
            if (out_eop) last_in_done = 0;
            got++;
          end
          sp = out_valid && !out_ready; pd = out_data; ps = out_sop; pe = out_eop;
        end
      end
    join
    out_ready = 1;
    for (int i = 0; i < K; i++) chk(cw[i] == msg[i], "R2 message bit", int'(cw[i]), int'(msg[i]));
    ep = model(msg);
    for (int j = 0; j < NP; j++) rp[j] = cw[K+j];
    chk(rp == ep, ptag, int'(rp), int'(ep));
    syn = rp ^ model(cw[K-1:0]);
    chk(syn == '0, "R3 syndrome", int'(syn), 0);
    for (int b = 0; b < N; b++) begin
      chk(sops[b] == (b == 0), "R9 sop position", int'(sops[b]), int'(b == 0));
      chk(eops[b] == (b == N-1), "R9 eop position", int'(eops[b]), int'(b == N-1));
    end
    chk(!gate_err, "R7 input held off", int'(gate_err), 0);
    chk(!stall_err, "R8 stall hold", int'(stall_err), 0);
    if (mode == 0) begin
      for (int i = 1; i < K; i++) chk(acc_st[i] == acc_st[i-1] + 1, "R6 back-to-back accept", acc_st[i] - acc_st[i-1], 1);
      chk(out_st[0] == acc_st[0] + 2, "R6 first output latency", out_st[0] - acc_st[0], 2);
      for (int b = 1; b < N; b++) chk(out_st[b] == out_st[b-1] + 1, "R6 contiguous output", out_st[b] - out_st[b-1], 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] cw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready after reset", int'(in_ready), 1);

    // reference table: c1->p0,p2  c2->p0,p1,p2  c3->p1,p2
    set_slot(0,0,1,0); set_slot(0,1,1,2); set_slot(0,2,0,0);
    set_slot(1,0,1,0); set_slot(1,1,1,1); set_slot(1,2,1,2);
    set_slot(2,0,1,1); set_slot(2,1,1,2); set_slot(2,2,0,0);
    load_table();

    run_block(3'b011, 0, "R3 parity", cw);   // c1=1 c2=1 c3=0
    chk(cw == 6'b010011, "R3 reference 110->110010", int'(cw), int'(6'b010011));

    for (int m = 0; m < 8; m++) run_block(3'(m), 0, "R3 parity", cw);
    for (int m = 0; m < 8; m++) run_block(3'(m), 1, "R3 parity under stall", cw);

    run_block(3'b111, 0, "R5 parity", cw);
    run_block(3'b000, 0, "R5 parity after clear", cw);
    chk(cw[N-1:K] == '0, "R5 zero parity after busy block", int'(cw[N-1:K]), 0);

    // R4 table: disabled slots, cancelling duplicates, out-of-range index
    set_slot(0,0,1,0); set_slot(0,1,0,1); set_slot(0,2,1,0);
    set_slot(1,0,1,0); set_slot(1,1,1,1); set_slot(1,2,0,2);
    set_slot(2,0,1,2); set_slot(2,1,1,3); set_slot(2,2,0,1);
    load_table();
    for (int m = 0; m < 8; m++) run_block(3'(m), 1, "R4 slot rules", cw);
    run_block(3'b001, 0, "R4 slot rules", cw);
    chk(cw[N-1:K] == '0, "R4 cancelled c1 gives zero parity", int'(cw[N-1:K]), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule